// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block is the command interface of a byte-wide NOR flash that uses the classic two-write unlock protocol. Every write on the bus port is one step of a command sequence. The protocol starts with a write of 0xAA to unlock address UA0, followed by a write of 0x55 to unlock address UA1. After that, one command byte selects an operation: program, erase, autoselect (ID read) or unlock bypass. Erase is the only operation that asks for a second unlock pair before its final byte. The storage is a small on-chip byte array that powers up erased (all bytes 0xFF). Program and erase times come from cycle counters.

Reads use a separate strobe and return one of three things. In the normal case they return array data. In autoselect mode they return ID bytes. While a program or erase runs they return a status byte, whose toggle bits let software poll for completion. A sector erase can be paused, other sectors can be programmed while it is paused, and the erase can then be resumed. Unlock bypass lets a host issue repeated programs without the two unlock writes.

Top module: `nor_cmd_seq`

## Requirements
- R1: After `rst` the block is in read mode, `busy` is 0 and bypass is off. A sequence that was half written before the reset is forgotten. `rdata` shows the result of a read in the cycle after the edge that samples `rd_en`.
- R2: A sequence begins only with 0xAA at UA0 (default 0x15), followed by 0x55 at UA1 (default 0x2A). Any other second write returns the block to read mode, and the writes that follow are not taken as commands.
- R3: The command bytes are AA, 55 and then A0, followed by one data write. That write stores the old byte AND the new data at the written address. `busy` stays high for PROG_CYC cycles.
- R4: While `busy` is high, each read returns a status byte. Bit 6 inverts on every read. Bit 2 inverts on every read during an erase and holds its value during a program. All other bits read 0.
- R5: The bytes AA, 55, 80, AA, 55 and then 0x10 at UA0 start a chip erase. It lasts 2^CHIP_EXP × UNIT cycles and leaves every byte at 0xFF. Writes made during the chip erase are ignored.
- R6: A final byte of 0x10 written to any address other than UA0 returns the block to read mode and erases nothing.
- R7: A final byte of 0x30 erases the sector that holds the written address. The sector number is addr[AW-1:AW-SECT_BITS] (default addr[5:4]). Bytes in other sectors keep their values.
- R8: Reads made between the writes of the second erase unlock pair return array data.
- R9: After AA, 55, 90, reads return MFR_ID at addr[1:0]=0 and DEV_ID at addr[1:0]=1, and 0x00 at any other offset. The next write returns the block to read mode.
- R10: After AA, 55, 0x20 the block is in bypass mode. In this mode A0 followed by a data write programs a byte with no unlock writes. Writing 0x90 and then 0x00 leaves bypass, and a later A0 is not treated as a command.
- R11: Writing 0xB0 during a sector erase pauses it, and `busy` drops. While paused, reads return array data, a program aimed at the paused sector is ignored, and a program aimed at another sector completes. Writing 0x30 resumes the erase, which then finishes.
- R12: A 0xB0 written when no sector erase is running has no effect, including during a program. Writing 0xF0 at any step of a sequence before its final write returns the block to read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Write strobe, one bus write per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Byte address for both reads and writes |
| wdata | input | 8 | Write data or command byte |
| rdata | output | 8 | Array data, ID byte or status byte |
| busy | output | 1 | A program or erase is running |

## Verification
The properties assume that `we` and `rd_en` are never high in the same cycle. They also assume that `addr` and `wdata` are stable for the whole cycle in which a strobe is high. The bench keeps to this: every bus operation goes through a task that raises exactly one strobe for one cycle, and all inputs change on the falling clock edge. The bench also never starts a new command until the busy window it expects has ended, except where a requirement calls for writes or reads during that window.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  typedef enum logic [3:0] {
    S_READ, S_U1, S_U2, S_PGM, S_E3, S_E4, S_E5, S_AUTO,
    S_BPROG, S_BCHIP, S_BSECT
  } seq_st_e;

  typedef enum logic [1:0] {RS_ARR, RS_ID, RS_STAT} rsel_e;

  localparam logic [7:0] C_KEY1  = 8'hAA;
  localparam logic [7:0] C_KEY2  = 8'h55;
  localparam logic [7:0] C_BYP   = 8'h20;
  localparam logic [7:0] C_ERS   = 8'h80;
  localparam logic [7:0] C_ID    = 8'h90;
  localparam logic [7:0] C_PGM   = 8'hA0;
  localparam logic [7:0] C_CHIP  = 8'h10;
  localparam logic [7:0] C_SECT  = 8'h30;
  localparam logic [7:0] C_PAUSE = 8'hB0;
  localparam logic [7:0] C_ABORT = 8'hF0;
  localparam logic [7:0] C_BYPX  = 8'h00;
endpackage

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (en && cnt != '0)  cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/nor_cell_array.sv
module nor_cell_array #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic [AW-1:0] a_addr,
  output logic [DW-1:0] a_q,
  input  logic [AW-1:0] b_addr,
  input  logic          b_we,
  input  logic [DW-1:0] b_d,
  output logic [DW-1:0] b_q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  // power-up content: erased
  initial for (int i = 0; i < DEPTH; i++) mem[i] = '1;

  always_ff @(posedge clk) begin
    if (a_en) a_q <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_d;
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int            AW        = 6,
  parameter int            SECT_BITS = 2,
  parameter logic [AW-1:0] UA0       = 'h15,
  parameter logic [AW-1:0] UA1       = 'h2A,
  parameter int            UNIT      = 16,
  parameter int            CHIP_EXP  = 3,
  parameter int            SECT_EXP  = 2,
  parameter int            PROG_CYC  = 8,
  parameter logic [7:0]    MFR_ID    = 8'h01,
  parameter logic [7:0]    DEV_ID    = 8'h7E
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          busy
);
  localparam int SW     = AW - SECT_BITS;
  localparam int CHIP_N = (1 << CHIP_EXP) * UNIT;
  localparam int SECT_N = (1 << SECT_EXP) * UNIT;
  localparam int MAX_N  = (CHIP_N > SECT_N) ? CHIP_N : SECT_N;
  localparam int EW     = $clog2(MAX_N);
  localparam int PW     = $clog2(PROG_CYC);

  seq_st_e st, st_n;
  rsel_e   rsel_q;
  logic    bypass, byp_n, susp, susp_n, chip_kind, tog6, tog2;
  logic [SECT_BITS-1:0] es_sect;
  logic [AW-1:0] p_addr, sweep, b_addr;
  logic [7:0]    p_data, id_q, a_q, b_q, b_d;
  logic [EW-1:0] e_cnt, e_load_val;
  logic [PW-1:0] p_cnt;
  logic key1, key2, p_load, e_load, p_done, e_done, e_en, b_we;

  assign key1   = we && addr == UA0 && wdata == C_KEY1;
  assign key2   = we && addr == UA1 && wdata == C_KEY2;
  assign e_en   = (st == S_BCHIP) || (st == S_BSECT);
  assign busy   = e_en || (st == S_BPROG);
  assign p_done = (st == S_BPROG) && (p_cnt == '0);
  assign e_done = e_en && (e_cnt == '0);
  assign p_load = (st == S_PGM) && we && wdata != C_ABORT &&
                  !(susp && addr[AW-1:SW] == es_sect);
  assign e_load = (st == S_E5) && we &&
                  ((wdata == C_CHIP && addr == UA0) || wdata == C_SECT);
  assign e_load_val = (wdata == C_CHIP) ? EW'(CHIP_N - 1) : EW'(SECT_N - 1);
  assign sweep  = AW'(e_cnt);

  nor_busy_timer #(.W(PW)) u_ptim (
    .clk(clk), .rst(rst), .load(p_load), .load_val(PW'(PROG_CYC - 1)),
    .en(st == S_BPROG), .cnt(p_cnt));

  nor_busy_timer #(.W(EW)) u_etim (
    .clk(clk), .rst(rst), .load(e_load), .load_val(e_load_val),
    .en(e_en), .cnt(e_cnt));

  always_comb begin
    st_n = st; byp_n = bypass; susp_n = susp;
    case (st)
      S_READ: if (we) begin
        if (susp && wdata == C_SECT) begin st_n = S_BSECT; susp_n = 1'b0; end
        else if (bypass) begin
          if (wdata == C_PGM)     st_n = S_PGM;
          else if (wdata == C_ID) st_n = S_AUTO;
        end else if (key1) st_n = S_U1;
      end
      S_U1: if (we) st_n = key2 ? S_U2 : S_READ;
      S_U2: if (we) begin
        st_n = S_READ;
        case (wdata)
          C_BYP:   byp_n = 1'b1;
          C_ERS:   if (!susp) st_n = S_E3;
          C_ID:    st_n = S_AUTO;
          C_PGM:   st_n = S_PGM;
          default: st_n = S_READ;
        endcase
      end
      S_PGM: if (we) st_n = p_load ? S_BPROG : S_READ;
      S_E3:  if (we) st_n = key1 ? S_E4 : S_READ;
      S_E4:  if (we) st_n = key2 ? S_E5 : S_READ;
      S_E5:  if (we) st_n = !e_load ? S_READ : (wdata == C_CHIP ? S_BCHIP : S_BSECT);
      S_AUTO: if (we) begin
        st_n = S_READ;
        if (bypass && wdata == C_BYPX) byp_n = 1'b0;
      end
      S_BPROG: if (p_done) st_n = S_READ;
      S_BCHIP: if (e_done) st_n = S_READ;
      S_BSECT: begin
        if (e_done) st_n = S_READ;
        else if (we && wdata == C_PAUSE) begin st_n = S_READ; susp_n = 1'b1; end
      end
      default: st_n = S_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_READ; bypass <= 1'b0; susp <= 1'b0;
      chip_kind <= 1'b0; es_sect <= '0; p_addr <= '0; p_data <= '0;
    end else begin
      st <= st_n; bypass <= byp_n; susp <= susp_n;
      if (e_load) begin
        chip_kind <= (wdata == C_CHIP);
        es_sect   <= addr[AW-1:SW];
      end
      if (p_load) begin p_addr <= addr; p_data <= wdata; end
    end
  end

  // internal port: erase sweep or program read-modify-write
  always_comb begin
    b_addr = sweep; b_we = 1'b0; b_d = '1;
    if (st == S_BPROG) begin
      b_addr = p_addr; b_we = p_done; b_d = b_q & p_data;
    end else if (e_en) begin
      b_we = chip_kind || (sweep[AW-1:SW] == es_sect);
    end
  end

  nor_cell_array #(.AW(AW), .DW(8)) u_mem (
    .clk(clk), .a_en(rd_en), .a_addr(addr), .a_q(a_q),
    .b_addr(b_addr), .b_we(b_we), .b_d(b_d), .b_q(b_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q <= RS_ARR; tog6 <= 1'b0; tog2 <= 1'b0; id_q <= '0;
    end else if (rd_en) begin
      if (busy) begin
        rsel_q <= RS_STAT;
        tog6   <= ~tog6;
        if (e_en) tog2 <= ~tog2;
      end else if (st == S_AUTO) begin
        rsel_q <= RS_ID;
        case (addr[1:0])
          2'd0:    id_q <= MFR_ID;
          2'd1:    id_q <= DEV_ID;
          default: id_q <= 8'h00;
        endcase
      end else rsel_q <= RS_ARR;
    end
  end

  always_comb begin
    case (rsel_q)
      RS_STAT: rdata = {1'b0, tog6, 3'b000, tog2, 2'b00};
      RS_ID:   rdata = id_q;
      default: rdata = a_q;
    endcase
  end
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk
  import nor_seq_pkg::*;
#(
  parameter int            AW  = 6,
  parameter logic [AW-1:0] UA0 = 'h15
) (
  input logic          clk,
  input logic          rst,
  input logic          we,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [7:0]    wdata,
  input logic [7:0]    rdata,
  input logic          busy,
  input seq_st_e       st,
  input logic          susp,
  input rsel_e         rsel_q
);
  a_r4_bit6_flips: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_en && rsel_q == RS_STAT) |=> (rdata[6] != $past(rdata[6])));

  a_r4_bit2_holds_in_program: assert property (@(posedge clk) disable iff (rst)
    (st == S_BPROG && rd_en && rsel_q == RS_STAT) |=> (rdata[2] == $past(rdata[2])));

  a_r5_chip_erase_deaf: assert property (@(posedge clk) disable iff (rst)
    (st == S_BCHIP) |=> (st == S_BCHIP || st == S_READ));

  a_r6_chip_needs_ua0: assert property (@(posedge clk) disable iff (rst)
    (st == S_E5 && we && wdata == C_CHIP && addr != UA0) |=> (st == S_READ && !busy));

  a_r7_second_unlock_first: assert property (@(posedge clk) disable iff (rst)
    (st == S_E5) |-> ($past(st) == S_E4 || $past(st) == S_E5));

  a_r11_pause_drops_busy: assert property (@(posedge clk) disable iff (rst)
    (st == S_BSECT && we && wdata == C_PAUSE) |=> !busy);

  a_r11_no_erase_while_paused: assert property (@(posedge clk) disable iff (rst)
    susp |-> !(st == S_BCHIP || st == S_BSECT));
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.AW(AW), .UA0(UA0)) u_chk (
  .clk(clk), .rst(rst), .we(we), .rd_en(rd_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .busy(busy), .st(st), .susp(susp), .rsel_q(rsel_q));

// File: tb/sim_nor_cmd_seq.sv
module sim_nor_cmd_seq;
  logic clk = 1'b0, rst = 1'b1, we = 1'b0, rd_en = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic busy;
  int errs = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nor_cmd_seq u0 (.clk(clk), .rst(rst), .we(we), .rd_en(rd_en), .addr(addr),
                  .wdata(wdata), .rdata(rdata), .busy(busy));

  // {kind, req, addr, data}: kind 0 write, 1 read+check, 2 idle (data = cycles)
  localparam int NV = 46;
  localparam logic [21:0] VEC [NV] = '{
    {2'd1,4'd1,8'h00,8'hFF},                                  // R1 erased at power-up
    {2'd0,4'd3,8'h15,8'hAA},{2'd0,4'd3,8'h2A,8'h55},
    {2'd0,4'd3,8'h15,8'hA0},{2'd0,4'd3,8'h05,8'h3C},
    {2'd2,4'd3,8'h00,8'h0A},{2'd1,4'd3,8'h05,8'h3C},           // R3 program
    {2'd0,4'd3,8'h15,8'hAA},{2'd0,4'd3,8'h2A,8'h55},
    {2'd0,4'd3,8'h15,8'hA0},{2'd0,4'd3,8'h05,8'h0F},
    {2'd2,4'd3,8'h00,8'h0A},{2'd1,4'd3,8'h05,8'h0C},           // R3 AND merge
    {2'd0,4'd2,8'h15,8'hAA},{2'd0,4'd2,8'h2B,8'h55},
    {2'd0,4'd2,8'h15,8'hA0},{2'd0,4'd2,8'h06,8'h00},
    {2'd2,4'd2,8'h00,8'h0A},{2'd1,4'd2,8'h06,8'hFF},           // R2 bad unlock
    {2'd0,4'd9,8'h15,8'hAA},{2'd0,4'd9,8'h2A,8'h55},{2'd0,4'd9,8'h15,8'h90},
    {2'd1,4'd9,8'h00,8'h01},{2'd1,4'd9,8'h01,8'h7E},{2'd1,4'd9,8'h02,8'h00},
    {2'd0,4'd9,8'h00,8'hF0},{2'd1,4'd9,8'h05,8'h0C},           // R9 autoselect
    {2'd0,4'd12,8'h15,8'hAA},{2'd0,4'd12,8'h2A,8'h55},
    {2'd0,4'd12,8'h00,8'hF0},{2'd0,4'd12,8'h07,8'h00},
    {2'd2,4'd12,8'h00,8'h04},{2'd1,4'd12,8'h07,8'hFF},         // R12 abort
    {2'd0,4'd10,8'h15,8'hAA},{2'd0,4'd10,8'h2A,8'h55},{2'd0,4'd10,8'h15,8'h20},
    {2'd0,4'd10,8'h00,8'hA0},{2'd0,4'd10,8'h08,8'h55},
    {2'd2,4'd10,8'h00,8'h0A},{2'd1,4'd10,8'h08,8'h55},
    {2'd0,4'd10,8'h00,8'h90},{2'd0,4'd10,8'h00,8'h00},
    {2'd0,4'd10,8'h00,8'hA0},{2'd0,4'd10,8'h09,8'h00},
    {2'd2,4'd10,8'h00,8'h0A},{2'd1,4'd10,8'h09,8'hFF}          // R10 bypass
  };

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    we = 1'b1; addr = a[5:0]; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    rd_en = 1'b1; addr = a[5:0];
    @(negedge clk);
    rd_en = 1'b0; v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock(input logic [7:0] cmd);
    wr(8'h15, 8'hAA); wr(8'h2A, 8'h55); wr(8'h15, cmd);
  endtask

  task automatic erase_seq(input logic [7:0] a, input logic [7:0] cmd);
    unlock(8'h80); wr(8'h15, 8'hAA); wr(8'h2A, 8'h55); wr(a, cmd);
  endtask

  task automatic prog(input logic [7:0] a, input logic [7:0] d);
    unlock(8'hA0); wr(a, d); idle(10);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] v, s1, s2;
    idle(3);
    rst = 1'b0;
    chk(busy == 1'b0, "R1 busy after reset", {7'd0, busy}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [21:0] e;
      e = VEC[i];
      case (e[21:20])
        2'd0: wr(e[15:8], e[7:0]);
        2'd1: begin
          rd(e[15:8], v);
          chk(v == e[7:0], $sformatf("R%0d table step %0d", e[19:16], i), v, e[7:0]);
        end
        default: idle(int'(e[7:0]));
      endcase
    end

    // R1: reset drops bypass and a pending sequence
    unlock(8'h20); wr(8'h15, 8'hAA);
    rst = 1'b1; idle(2); rst = 1'b0;
    chk(busy == 1'b0, "R1 busy after mid-run reset", {7'd0, busy}, 8'h00);
    wr(8'h00, 8'hA0); wr(8'h0A, 8'h00); idle(10);
    rd(8'h0A, v); chk(v == 8'hFF, "R1 bypass cleared by reset", v, 8'hFF);

    // R4 program status, R12 pause ignored during program
    unlock(8'hA0); wr(8'h0B, 8'h11);
    rd(8'h0B, s1); wr(8'h00, 8'hB0); rd(8'h0B, s2);
    chk(busy == 1'b1, "R12 pause ignored in program", {7'd0, busy}, 8'h01);
    chk(s1[6] != s2[6], "R4 bit6 flips in program", s2, s1 ^ 8'h40);
    chk(s1[2] == s2[2], "R4 bit2 holds in program", s2, s1);
    chk((s1 & 8'hBB) == 8'h00, "R4 other status bits zero", s1 & 8'hBB, 8'h00);
    idle(10);
    rd(8'h0B, v); chk(v == 8'h11, "R3 program after status", v, 8'h11);

    // R5 chip erase, writes during it ignored
    erase_seq(8'h15, 8'h10);
    rd(8'h00, s1); rd(8'h00, s2);
    chk(s1[2] != s2[2], "R4 bit2 flips in chip erase", s2, s1 ^ 8'h04);
    chk(s1[6] != s2[6], "R4 bit6 flips in chip erase", s2, s1 ^ 8'h40);
    unlock(8'h90);
    chk(busy == 1'b1, "R5 busy during chip erase", {7'd0, busy}, 8'h01);
    idle(140);
    chk(busy == 1'b0, "R5 busy ends", {7'd0, busy}, 8'h00);
    rd(8'h00, v); chk(v == 8'hFF, "R5 writes ignored, no autoselect", v, 8'hFF);
    rd(8'h05, v); chk(v == 8'hFF, "R5 byte 05 erased", v, 8'hFF);
    rd(8'h0B, v); chk(v == 8'hFF, "R5 byte 0B erased", v, 8'hFF);

    // R6 chip erase at wrong address
    prog(8'h10, 8'h00);
    erase_seq(8'h16, 8'h10);
    chk(busy == 1'b0, "R6 no erase started", {7'd0, busy}, 8'h00);
    idle(2);
    rd(8'h10, v); chk(v == 8'h00, "R6 data kept", v, 8'h00);

    // R7 sector erase
    prog(8'h20, 8'h00);
    erase_seq(8'h13, 8'h30);
    rd(8'h00, s1); rd(8'h00, s2);
    chk(s1[2] != s2[2], "R4 bit2 flips in sector erase", s2, s1 ^ 8'h04);
    idle(70);
    rd(8'h10, v); chk(v == 8'hFF, "R7 sector 1 erased", v, 8'hFF);
    rd(8'h20, v); chk(v == 8'h00, "R7 sector 2 kept", v, 8'h00);

    // R8 reads between second unlock writes
    prog(8'h21, 8'h5A);
    unlock(8'h80); wr(8'h15, 8'hAA);
    rd(8'h21, v); chk(v == 8'h5A, "R8 read after fourth write", v, 8'h5A);
    wr(8'h2A, 8'h55);
    rd(8'h21, v); chk(v == 8'h5A, "R8 read after fifth write", v, 8'h5A);
    wr(8'h15, 8'hF0);
    chk(busy == 1'b0, "R12 abort before final erase byte", {7'd0, busy}, 8'h00);
    rd(8'h20, v); chk(v == 8'h00, "R12 nothing erased", v, 8'h00);

    // R11 pause / resume
    prog(8'h30, 8'h00);
    erase_seq(8'h33, 8'h30);
    idle(3);
    wr(8'h00, 8'hB0);
    chk(busy == 1'b0, "R11 busy drops on pause", {7'd0, busy}, 8'h00);
    rd(8'h08, v); chk(v == 8'hFF, "R11 array read while paused", v, 8'hFF);
    unlock(8'hA0); wr(8'h35, 8'h00);
    chk(busy == 1'b0, "R11 program to paused sector not started", {7'd0, busy}, 8'h00);
    rd(8'h35, v); chk(v == 8'hFF, "R11 paused sector byte untouched", v, 8'hFF);
    prog(8'h08, 8'h0F);
    rd(8'h08, v); chk(v == 8'h0F, "R11 program to other sector", v, 8'h0F);
    wr(8'h00, 8'h30);
    chk(busy == 1'b1, "R11 resume sets busy", {7'd0, busy}, 8'h01);
    idle(80);
    chk(busy == 1'b0, "R11 resumed erase ends", {7'd0, busy}, 8'h00);
    rd(8'h30, v); chk(v == 8'hFF, "R11 sector 3 erased", v, 8'hFF);
    rd(8'h08, v); chk(v == 8'h0F, "R11 sector 0 kept", v, 8'h0F);

    // R12 pause byte in read mode
    wr(8'h00, 8'hB0);
    chk(busy == 1'b0, "R12 pause in read mode", {7'd0, busy}, 8'h00);
    rd(8'h08, v); chk(v == 8'h0F, "R12 array unchanged", v, 8'h0F);

    finish_run();
  end
endmodule